// File: doc/BRIEF.md
# Receive Sampling Delay Trainer

This block calibrates the receive sampling point of a double-data-rate flash interface. After bringing the delay-line PHY through its initialisation sequence, it walks the receive delay taps upward from zero. At each tap it re-locks the DLL, then asks the flash command path for an identification read, and repeats that read several times to decide whether the tap samples reliably. Runs of good taps form windows. The width of a window is measured on the receive tap value that the PHY reports back.

The whole sweep is done twice: once with the normal read latency and once with one additional dummy cycle. The widest window seen across both sweeps wins, and its centre tap is programmed into the PHY. The dummy-cycle setting that produced it is reported so that later reads use the same latency. A sweep ends early as soon as a window of useful width has closed. A small start/enable/done/fail control interface runs the engine. After one successful run the result is frozen until reset.

The read interface is a request/completion handshake. `rd_req` rises to ask for one identification read and stays high until the command path answers with a one-cycle `rd_done`, which carries the comparison result on `rd_match`. The command path may stall for any number of cycles, and that stall is the only back-pressure. The engine drops `rd_req` in the cycle after `rd_done` and raises it again at least one cycle later for the next read.

Top module: `tap_train_engine`

## Requirements
- R1: After reset `done`, `fail`, `tuned`, `rd_req`, `extra_dummy`, `phy_dll_rst` and `phy_rx_tap` are all 0. `phy_tx_dly` is held at 0x1E at all times.
- R2: A training run first drives `phy_dll_rst` low and loads 4 on `phy_master_dly`. It then raises `phy_dll_rst`, waits for `lpbk_lock`, and only then raises `phy_resync` with `phy_dll_rst` still high.
- R3: Each tap is applied on `phy_rx_tap` while `phy_dll_rst` is high with `phy_resync` low. `phy_resync` is then raised. No read is requested until `dll_lock` is high. Taps go in ascending order starting at 0.
- R4: A tap is valid only after 10 consecutive matching reads. The first mismatch rejects the tap, and no further read is issued at that tap.
- R5: A window opens at the first valid tap. It closes at the first invalid tap, or at tap 127. Its size is the largest observed receive tap minus the smallest, plus one.
- R6: When a window of size 3 or more closes, the remaining taps of that sweep are skipped.
- R7: Two sweeps run: the first with `extra_dummy`=0 and the second with `extra_dummy`=1.
- R8: The best window is replaced only by a strictly larger one, so on a tie the first sweep wins. The chosen tap is (first valid index + last valid index)/2, rounded down.
- R9: If the best size is below 3 after both sweeps, `fail` rises and `done` stays low. Otherwise the chosen tap is applied with the reset-then-resync sequence. After `dll_lock`, `done` and `tuned` rise, `phy_rx_tap` equals `best_tap`, and `extra_dummy` holds the winning sweep's value.
- R10: If any lock wait lasts `lock_limit` cycles without lock, `fail` rises and the engine returns to idle, ready for a new start.
- R11: A `start` with `enable` low completes in the next cycle with `done`=1 and `fail`=0. No read is issued and no PHY output changes.
- R12: Once `tuned` is set it stays set until reset, and any later `start` is ignored.
- R13: `rd_req` stays high until `rd_done`, and goes low in the cycle after `rd_done`. `rd_match` is sampled only with `rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a training run (acted on while idle) |
| enable | input | 1 | Controller enabled; low makes a start a no-op completion |
| lock_limit | input | 16 | Cycles allowed for each lock wait |
| lpbk_lock | input | 1 | PHY loopback lock status |
| dll_lock | input | 1 | PHY DLL lock status |
| obs_rx_tap | input | 7 | Receive tap value reported by the PHY |
| rd_done | input | 1 | One-cycle completion of an identification read |
| rd_match | input | 1 | Read result matched the expected ID (valid with rd_done) |
| rd_req | output | 1 | Identification read request |
| phy_dll_rst | output | 1 | PHY DLL reset control |
| phy_resync | output | 1 | PHY DLL resynchronise control |
| phy_master_dly | output | 8 | PHY master initial delay |
| phy_tx_dly | output | 7 | PHY transmit delay (fixed) |
| phy_rx_tap | output | 7 | PHY receive delay tap |
| done | output | 1 | Run finished successfully (held until next accepted start) |
| fail | output | 1 | Run failed (held until next accepted start) |
| tuned | output | 1 | A successful calibration has been applied |
| best_tap | output | 7 | Centre tap of the best window |
| extra_dummy | output | 1 | Extra dummy cycle setting (current sweep, then winner) |

## Verification
A corrupted match counter changes the number of reads made at each tap. That count shows up on `rd_req` before the engine moves to the next tap, and the bench counts reads per tap and per sweep. A window tracker that fails to close or keeps a stale bound produces a wrong early stop. That is visible as reads issued past the expected last tap within a few dozen cycles, and as a wrong `best_tap` or `extra_dummy` at `done`. Sequencing faults appear as a `phy_resync` edge with the DLL reset low, or as a read request without lock, in the cycle they happen.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT_LOW,
    ST_INIT_RST,
    ST_WAIT_LPBK,
    ST_INIT_SYNC,
    ST_TAP_RST,
    ST_TAP_SYNC,
    ST_WAIT_DLL,
    ST_READ,
    ST_GAP,
    ST_EVAL,
    ST_DECIDE,
    ST_FIN_RST,
    ST_FIN_SYNC,
    ST_FIN_WAIT
  } tt_state_e;
endpackage

// File: rtl/tt_lock_wait.sv
module tt_lock_wait #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            lock_in,
  input  logic [TO_W-1:0] limit,
  output logic            locked,
  output logic            expired
);
  logic [TO_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wait_cnt <= '0;
    else if (!active)         wait_cnt <= '0;
    else if (wait_cnt != '1)  wait_cnt <= wait_cnt + 1'b1;
  end

  assign locked  = active & lock_in;
  assign expired = active & ~lock_in & (wait_cnt >= limit);
endmodule

// File: rtl/tt_read_qual.sv
module tt_read_qual #(
  parameter int QUAL_READS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hit,
  output logic last
);
  localparam int CW = $clog2(QUAL_READS + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(QUAL_READS - 1);

  logic [CW-1:0] hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hits <= '0;
    else if (clear) hits <= '0;
    else if (hit)   hits <= hits + 1'b1;
  end

  // current read is the final one needed to qualify the tap
  assign last = (hits == LAST_CNT);
endmodule

// File: rtl/tt_window.sv
module tt_window #(
  parameter int TAP_W   = 7,
  parameter int MIN_WIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             eval,
  input  logic             valid,
  input  logic [TAP_W-1:0] idx,
  input  logic [TAP_W-1:0] obs,
  input  logic             pass,
  output logic             close_big,
  output logic [TAP_W:0]   best_size,
  output logic [TAP_W-1:0] best_mid,
  output logic             best_pass
);
  localparam int SZ_W = TAP_W + 1;
  localparam logic [TAP_W-1:0] LAST_TAP = '1;
  localparam logic [SZ_W-1:0]  MIN_SZ   = SZ_W'(MIN_WIN);

  logic             open_q;
  logic [TAP_W-1:0] lo_obs, hi_obs, lo_idx, hi_idx;
  logic [TAP_W-1:0] n_lo_obs, n_hi_obs, n_lo_idx, n_hi_idx;
  logic             n_open, closing;
  logic [SZ_W-1:0]  size, mid_sum;
  logic [TAP_W-1:0] mid;

  always_comb begin
    n_open   = open_q | valid;
    n_lo_obs = (valid && !open_q) ? obs : lo_obs;
    n_lo_idx = (valid && !open_q) ? idx : lo_idx;
    n_hi_obs = valid ? obs : hi_obs;
    n_hi_idx = valid ? idx : hi_idx;
    closing  = eval && n_open && (!valid || idx == LAST_TAP);
    size     = {1'b0, n_hi_obs} - {1'b0, n_lo_obs} + 1'b1;
    mid_sum  = {1'b0, n_lo_idx} + {1'b0, n_hi_idx};
    mid      = TAP_W'(mid_sum >> 1);
  end

  assign close_big = closing && (size >= MIN_SZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      lo_obs <= '0; hi_obs <= '0; lo_idx <= '0; hi_idx <= '0;
      best_size <= '0; best_mid <= '0; best_pass <= 1'b0;
    end else if (clear_all) begin
      open_q <= 1'b0;
      best_size <= '0; best_mid <= '0; best_pass <= 1'b0;
    end else if (eval) begin
      open_q <= n_open && !closing;
      lo_obs <= n_lo_obs; hi_obs <= n_hi_obs;
      lo_idx <= n_lo_idx; hi_idx <= n_hi_idx;
      if (closing && size > best_size) begin
        best_size <= size;
        best_mid  <= mid;
        best_pass <= pass;
      end
    end
  end
endmodule

// File: rtl/tap_train_engine.sv
module tap_train_engine #(
  parameter int TAP_W      = 7,
  parameter int QUAL_READS = 10,
  parameter int MIN_WIN    = 3,
  parameter int TO_W       = 16,
  parameter int MDLY_W     = 8,
  parameter int INIT_DLY   = 4,
  parameter int TX_DLY     = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              enable,
  input  logic [TO_W-1:0]   lock_limit,
  input  logic              lpbk_lock,
  input  logic              dll_lock,
  input  logic [TAP_W-1:0]  obs_rx_tap,
  input  logic              rd_done,
  input  logic              rd_match,
  output logic              rd_req,
  output logic              phy_dll_rst,
  output logic              phy_resync,
  output logic [MDLY_W-1:0] phy_master_dly,
  output logic [TAP_W-1:0]  phy_tx_dly,
  output logic [TAP_W-1:0]  phy_rx_tap,
  output logic              done,
  output logic              fail,
  output logic              tuned,
  output logic [TAP_W-1:0]  best_tap,
  output logic              extra_dummy
);
  import tt_pkg::*;

  localparam logic [TAP_W-1:0] LAST_TAP = '1;
  localparam logic [TAP_W:0]   MIN_SZ   = (TAP_W+1)'(MIN_WIN);

  tt_state_e        state;
  logic [TAP_W-1:0] tap;
  logic             pass, tap_ok;
  logic             lk_active, lk_in, lk_ok, lk_exp;
  logic             q_last, w_big, w_best_pass;
  logic [TAP_W:0]   w_best_size;

  assign phy_tx_dly  = TAP_W'(TX_DLY);
  assign extra_dummy = pass;

  assign lk_active = (state == ST_WAIT_LPBK) || (state == ST_WAIT_DLL) ||
                     (state == ST_FIN_WAIT);
  assign lk_in     = (state == ST_WAIT_LPBK) ? lpbk_lock : dll_lock;

  tt_lock_wait #(.TO_W(TO_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .active(lk_active), .lock_in(lk_in),
    .limit(lock_limit), .locked(lk_ok), .expired(lk_exp)
  );

  tt_read_qual #(.QUAL_READS(QUAL_READS)) u_qual (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_WAIT_DLL),
    .hit((state == ST_READ) && rd_done && rd_match), .last(q_last)
  );

  tt_window #(.TAP_W(TAP_W), .MIN_WIN(MIN_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .clear_all(state == ST_INIT_LOW),
    .eval(state == ST_EVAL), .valid(tap_ok), .idx(tap), .obs(obs_rx_tap),
    .pass(pass), .close_big(w_big), .best_size(w_best_size),
    .best_mid(best_tap), .best_pass(w_best_pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tap <= '0; pass <= 1'b0; tap_ok <= 1'b0;
      phy_dll_rst <= 1'b0; phy_resync <= 1'b0;
      phy_master_dly <= '0; phy_rx_tap <= '0;
      rd_req <= 1'b0; done <= 1'b0; fail <= 1'b0; tuned <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start && !tuned) begin
          done <= !enable;
          fail <= 1'b0;
          if (enable) begin
            pass  <= 1'b0;
            state <= ST_INIT_LOW;
          end
        end
        ST_INIT_LOW: begin
          phy_dll_rst    <= 1'b0;
          phy_resync     <= 1'b0;
          phy_master_dly <= MDLY_W'(INIT_DLY);
          state          <= ST_INIT_RST;
        end
        ST_INIT_RST: begin
          phy_dll_rst <= 1'b1;
          state       <= ST_WAIT_LPBK;
        end
        ST_WAIT_LPBK:
          if (lk_ok) state <= ST_INIT_SYNC;
          else if (lk_exp) begin fail <= 1'b1; state <= ST_IDLE; end
        ST_INIT_SYNC: begin
          phy_resync <= 1'b1;
          tap        <= '0;
          state      <= ST_TAP_RST;
        end
        ST_TAP_RST: begin
          phy_rx_tap <= tap;
          phy_resync <= 1'b0;
          state      <= ST_TAP_SYNC;
        end
        ST_TAP_SYNC: begin
          phy_resync <= 1'b1;
          state      <= ST_WAIT_DLL;
        end
        ST_WAIT_DLL:
          if (lk_ok) begin rd_req <= 1'b1; state <= ST_READ; end
          else if (lk_exp) begin fail <= 1'b1; state <= ST_IDLE; end
        ST_READ: if (rd_done) begin
          rd_req <= 1'b0;
          if (!rd_match)  begin tap_ok <= 1'b0; state <= ST_EVAL; end
          else if (q_last) begin tap_ok <= 1'b1; state <= ST_EVAL; end
          else state <= ST_GAP;
        end
        ST_GAP: begin
          rd_req <= 1'b1;
          state  <= ST_READ;
        end
        ST_EVAL:
          if (w_big || tap == LAST_TAP) begin
            if (!pass) begin
              pass  <= 1'b1;
              tap   <= '0;
              state <= ST_TAP_RST;
            end else state <= ST_DECIDE;
          end else begin
            tap   <= tap + 1'b1;
            state <= ST_TAP_RST;
          end
        ST_DECIDE:
          if (w_best_size < MIN_SZ) begin fail <= 1'b1; state <= ST_IDLE; end
          else begin pass <= w_best_pass; state <= ST_FIN_RST; end
        ST_FIN_RST: begin
          phy_rx_tap <= best_tap;
          phy_resync <= 1'b0;
          state      <= ST_FIN_SYNC;
        end
        ST_FIN_SYNC: begin
          phy_resync <= 1'b1;
          state      <= ST_FIN_WAIT;
        end
        ST_FIN_WAIT:
          if (lk_ok) begin done <= 1'b1; tuned <= 1'b1; state <= ST_IDLE; end
          else if (lk_exp) begin fail <= 1'b1; state <= ST_IDLE; end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tt_train_chk.sv
module tt_train_chk #(
  parameter int TAP_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             rd_done,
  input logic             phy_dll_rst,
  input logic             phy_resync,
  input logic [TAP_W-1:0] phy_rx_tap,
  input logic [TAP_W-1:0] best_tap,
  input logic             done,
  input logic             fail,
  input logic             tuned
);
  // R9
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R3
  resync_under_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_resync) |-> phy_dll_rst);

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |=> rd_req);

  // R13
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done) |=> !rd_req);

  // R12
  tuned_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tuned |=> tuned);

  // R9
  final_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tuned) |-> (phy_rx_tap == best_tap) && done);

  // R3
  req_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> phy_resync && phy_dll_rst);
endmodule

bind tap_train_engine tt_train_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_done(rd_done),
  .phy_dll_rst(phy_dll_rst), .phy_resync(phy_resync),
  .phy_rx_tap(phy_rx_tap), .best_tap(best_tap), .done(done),
  .fail(fail), .tuned(tuned)
);

// File: tb/tap_train_engine_test.sv
module tap_train_engine_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       enable = 1'b1;
  logic [15:0] lock_limit = 16'd40;
  logic       lpbk_lock, dll_lock;
  logic [6:0] obs_rx_tap;
  logic       rd_done = 1'b0, rd_match = 1'b0;
  logic       rd_req, phy_dll_rst, phy_resync, done, fail, tuned, extra_dummy;
  logic [7:0] phy_master_dly;
  logic [6:0] phy_tx_dly, phy_rx_tap, best_tap;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_train_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
    .lock_limit(lock_limit), .lpbk_lock(lpbk_lock), .dll_lock(dll_lock),
    .obs_rx_tap(obs_rx_tap), .rd_done(rd_done), .rd_match(rd_match),
    .rd_req(rd_req), .phy_dll_rst(phy_dll_rst), .phy_resync(phy_resync),
    .phy_master_dly(phy_master_dly), .phy_tx_dly(phy_tx_dly),
    .phy_rx_tap(phy_rx_tap), .done(done), .fail(fail), .tuned(tuned),
    .best_tap(best_tap), .extra_dummy(extra_dummy)
  );

  int n_cmp = 0, n_bad = 0;
  // window model: per sweep, two good ranges and one flaky tap
  int lo_a[2], hi_a[2], lo_b[2], hi_b[2];
  int flaky_tap = -1, flaky_pass = 0;
  bit lpbk_ok = 1'b1;
  int reads_at[2][128];
  int tot_reads = 0;
  int rdn = 0;
  bit busy = 1'b0;
  int dly = 0;
  bit m_next = 1'b0;
  int dcnt = 0, lcnt = 0;
  int init_err = 0, seq_err = 0, unlk_err = 0, hs_err = 0, tx_err = 0;
  bit lpbk_seen = 1'b0, rst_seen = 1'b0;
  logic prev_rst = 1'b0, prev_sync = 1'b0, prev_req = 1'b0;

  assign dll_lock   = phy_resync && (dcnt >= 3);
  assign lpbk_lock  = phy_dll_rst && (lcnt >= 3) && lpbk_ok;
  assign obs_rx_tap = phy_rx_tap;

  function automatic bit good(input int p, input int t);
    return (t >= lo_a[p] && t <= hi_a[p]) || (t >= lo_b[p] && t <= hi_b[p]);
  endfunction

  function automatic int last_read_tap(input int p);
    int r = -1;
    for (int t = 0; t < 128; t++) if (reads_at[p][t] != 0) r = t;
    return r;
  endfunction

  // PHY lock model and flash read model
  always @(posedge clk) begin
    dcnt <= phy_resync  ? ((dcnt < 7) ? dcnt + 1 : dcnt) : 0;
    lcnt <= phy_dll_rst ? ((lcnt < 7) ? lcnt + 1 : lcnt) : 0;
    rd_done <= 1'b0;
    if (busy) begin
      if (!rd_req) hs_err <= hs_err + 1;
      if (dly == 0) begin
        rd_done  <= 1'b1;
        rd_match <= m_next;
        busy     <= 1'b0;
      end else dly <= dly - 1;
    end else if (rd_req && !rd_done && rst_n) begin
      busy   <= 1'b1;
      dly    <= 1;
      m_next <= good(int'(extra_dummy), int'(phy_rx_tap)) &&
                !(int'(phy_rx_tap) == flaky_tap && int'(extra_dummy) == flaky_pass && rdn >= 9);
      reads_at[extra_dummy][phy_rx_tap] <= reads_at[extra_dummy][phy_rx_tap] + 1;
      tot_reads <= tot_reads + 1;
      rdn <= rdn + 1;
    end
    if (!phy_resync) rdn <= 0;
  end

  // sequencing monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (phy_tx_dly !== 7'h1E) tx_err <= tx_err + 1;
      if (lpbk_lock) lpbk_seen <= 1'b1;
      if (phy_dll_rst && !prev_rst && !rst_seen) begin
        rst_seen <= 1'b1;
        if (phy_master_dly !== 8'd4) init_err <= init_err + 1;
      end
      if (phy_resync && !prev_sync) begin
        if (!phy_dll_rst) seq_err <= seq_err + 1;
        if (!lpbk_seen)   init_err <= init_err + 1;
      end
      if (rd_req && !prev_req && !dll_lock) unlk_err <= unlk_err + 1;
    end
    prev_rst  <= phy_dll_rst;
    prev_sync <= phy_resync;
    prev_req  <= rd_req;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_win(input int p, input int la, input int ha, input int lb, input int hb);
    lo_a[p] = la; hi_a[p] = ha; lo_b[p] = lb; hi_b[p] = hb;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; enable = 1'b1; lpbk_ok = 1'b1;
    flaky_tap = -1;
    repeat (2) @(negedge clk);
    for (int p = 0; p < 2; p++) for (int t = 0; t < 128; t++) reads_at[p][t] = 0;
    init_err = 0; seq_err = 0; unlk_err = 0; hs_err = 0; tx_err = 0;
    lpbk_seen = 1'b0; rst_seen = 1'b0; tot_reads = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!done && !fail && n < 60000) begin @(negedge clk); n++; end
    chk("R10 run finished before watchdog", int'(done || fail), 1);
  endtask

  task automatic chk_mon();
    chk("R2 init order", init_err, 0);
    chk("R3 resync with reset high", seq_err, 0);
    chk("R3 read only after DLL lock", unlk_err, 0);
    chk("R13 request held until completion", hs_err, 0);
    chk("R1 transmit delay fixed", tx_err, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 tuned", int'(tuned), 0);
    chk("R1 rd_req", int'(rd_req), 0);
    chk("R1 extra_dummy", int'(extra_dummy), 0);
    chk("R1 phy_dll_rst", int'(phy_dll_rst), 0);
    chk("R1 phy_rx_tap", int'(phy_rx_tap), 0);
    chk("R1 phy_tx_dly", int'(phy_tx_dly), 'h1E);
  endtask

  task automatic t_bypass();
    do_reset();
    enable = 1'b0;
    pulse_start();
    chk("R11 done next cycle", int'(done), 1);
    chk("R11 no fail", int'(fail), 0);
    repeat (10) @(negedge clk);
    chk("R11 no reads", tot_reads, 0);
    chk("R11 dll reset unchanged", int'(phy_dll_rst), 0);
    chk("R11 master delay unchanged", int'(phy_master_dly), 0);
    chk("R11 not tuned", int'(tuned), 0);
  endtask

  task automatic t_basic();
    do_reset();
    set_win(0, 10, 12, 40, 41);
    set_win(1, 20, 27, -1, -1);
    flaky_tap = 12; flaky_pass = 0;
    pulse_start();
    wait_end();
    chk("R4 flaky tap read ten times", reads_at[0][12], 10);
    chk("R4 valid tap read ten times", reads_at[1][20], 10);
    chk("R4 mismatch rejects at once", reads_at[1][28], 1);
    chk("R5 small windows close, sweep 0 runs to end", last_read_tap(0), 127);
    chk("R6 early stop in sweep 1", last_read_tap(1), 28);
    chk("R3 sweep starts at tap 0", reads_at[1][0], 1);
    chk("R8 midpoint", int'(best_tap), 23);
    chk("R7 winner sweep reported", int'(extra_dummy), 1);
    chk("R9 tap applied", int'(phy_rx_tap), 23);
    chk("R9 done", int'(done), 1);
    chk("R9 tuned", int'(tuned), 1);
    chk("R9 no fail", int'(fail), 0);
    chk("R2 master delay", int'(phy_master_dly), 4);
    chk_mon();
  endtask

  task automatic t_tie();
    do_reset();
    set_win(0, 30, 34, -1, -1);
    set_win(1, 50, 54, -1, -1);
    pulse_start();
    wait_end();
    chk("R6 sweep 0 stop", last_read_tap(0), 35);
    chk("R6 sweep 1 stop", last_read_tap(1), 55);
    chk("R8 tie keeps first sweep tap", int'(best_tap), 32);
    chk("R8 tie keeps first sweep dummy", int'(extra_dummy), 0);
    chk("R9 done on tie", int'(done), 1);
    chk_mon();
  endtask

  task automatic t_edge();
    do_reset();
    set_win(0, 124, 127, -1, -1);
    set_win(1, -1, -1, -1, -1);
    pulse_start();
    wait_end();
    chk("R5 window closes at tap 127", int'(best_tap), 125);
    chk("R7 sweep 1 still runs", last_read_tap(1), 127);
    chk("R7 winner dummy", int'(extra_dummy), 0);
    chk("R9 done edge", int'(done), 1);
    chk_mon();
  endtask

  task automatic t_ignore();
    int snap_tap, snap_dm, snap_reads;
    snap_tap = int'(phy_rx_tap); snap_dm = int'(extra_dummy); snap_reads = tot_reads;
    pulse_start();
    repeat (40) @(negedge clk);
    chk("R12 no reads after tuned", tot_reads - snap_reads, 0);
    chk("R12 tap unchanged", int'(phy_rx_tap), snap_tap);
    chk("R12 dummy unchanged", int'(extra_dummy), snap_dm);
    chk("R12 done held", int'(done), 1);
    chk("R12 tuned held", int'(tuned), 1);
  endtask

  task automatic t_fail();
    do_reset();
    set_win(0, 5, 6, -1, -1);
    set_win(1, 7, 8, -1, -1);
    pulse_start();
    wait_end();
    chk("R9 narrow windows fail", int'(fail), 1);
    chk("R9 no done on fail", int'(done), 0);
    chk("R9 not tuned on fail", int'(tuned), 0);
    chk("R6 no early stop below 3", last_read_tap(1), 127);
    chk_mon();
  endtask

  task automatic t_timeout();
    do_reset();
    lpbk_ok = 1'b0;
    set_win(0, 60, 70, -1, -1);
    set_win(1, -1, -1, -1, -1);
    pulse_start();
    wait_end();
    chk("R10 lock timeout fails", int'(fail), 1);
    chk("R10 no done", int'(done), 0);
    chk("R10 no reads", tot_reads, 0);
    lpbk_ok = 1'b1;
    @(negedge clk);
    pulse_start();
    chk("R10 fail cleared by new start", int'(fail), 0);
    wait_end();
    chk("R10 restart succeeds", int'(done), 1);
    chk("R8 midpoint after restart", int'(best_tap), 65);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_basic();
    t_tie();
    t_edge();
    t_ignore();
    t_fail();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule